// File: doc/BRIEF.md
# SPI Status-Register Write-Protection Controller

This block is the command front end of a 2 KB serial memory model with an SPI slave port. It takes SPI mode-0 traffic on its serial pins and decodes the commands that touch the status byte: set and clear the write-enable latch, read the status byte, and write the status byte. It also holds the nonvolatile protection bits, which are a two-bit protection level and a lock-enable bit. From these bits it decides whether the memory behind it may accept a write.

Two permit outputs come from this state. The array permit is evaluated combinationally for the address on the request port. It is false whenever the write-enable latch is clear, and false whenever the address lies in the range fenced off by the protection level. The status permit tells whether a status write would be honoured. It is false when the latch is clear, or when the external lock pin is driven low while the lock-enable bit is set. The lock pin never affects array writes.

The serial pins are assumed to be synchronous to `clk` already, with an SPI clock well below `clk`, so every SPI edge is seen as a level change between two system clocks. A status write commits only when chip-select rises after exactly 16 bits.

Top module: `spiwp_ctrl`

## Requirements
- R1: A frame of opcode 0x01 plus 8 data bits, shifted MSB first on SPI clock rising edges (16 edges), updates status bit 7 from data bit 7 and status bits 3:2 from data bits 3:2 on the rising chip-select. The update happens only if the write-enable latch is set and the hardware lock is inactive. The other data bits are ignored, and the status never changes while chip-select is low.
- R2: A status-write frame of any length other than 16 bits, shorter or longer, leaves the whole status byte unchanged, including the write-enable latch.
- R3: A complete 8-bit frame with opcode 0x06 sets the write-enable latch, and one with opcode 0x04 clears it.
- R4: The status byte reads {lock-enable, 0, 0, 0, level[1:0], write-enable latch, 0}. Reset clears it to 0x00.
- R5: The write-enable latch clears after each complete 16-bit status-write frame, whether or not the write was honoured. It also clears in the cycle after any array request strobe.
- R6: The hardware lock is active exactly when `wr_lock_n` is low and status bit 7 is high. While it is active, status writes are refused and `st_permit` is low. Otherwise `st_permit` equals the write-enable latch.
- R7: `wr_lock_n` has no effect on `req_permit`.
- R8: Protection level 00 fences no address, 01 fences 0x600–0x7FF, 10 fences 0x400–0x7FF and 11 fences 0x000–0x7FF. `req_permit` is low for a fenced address.
- R9: `req_permit` and `st_permit` are both low whenever the write-enable latch is clear.
- R10: `spi_miso_oe` is low whenever chip-select is high and throughout a status-write frame. It is high only in the data phase of a status read.
- R11: After the 8 bits of opcode 0x05, `spi_miso` presents the status byte MSB first. A new bit appears after each falling SPI clock edge, and the byte repeats for as long as clocking continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_clk | input | 1 | SPI serial clock, mode 0, synchronous to clk |
| spi_sel_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high-impedance |
| wr_lock_n | input | 1 | Hardware lock pin, active low |
| req_valid | input | 1 | One-cycle strobe marking an array write attempt |
| req_addr | input | ADDR_W | Array address under test |
| req_permit | output | 1 | Array write at req_addr is allowed |
| st_permit | output | 1 | A status write would be honoured |
| status_byte | output | 8 | Current status byte |

## Verification
A wrong protection level or lock-enable bit shows up on `req_permit` and `st_permit` in the same cycle, because both outputs are combinational from the status registers. A wrong bit counter or a wrong opcode capture shows up as a wrong `status_byte` one clock after the rising chip-select that closes the frame. A wrong read-out shift shows up on `spi_miso` one clock after the falling SPI edge that should have advanced it. The reference model is compared against all of these outputs on every clock, so a fault is reported in the cycle it first becomes visible.

// File: rtl/spiwp_pkg.sv
// Shared opcodes, frame lengths and the event record that the frame
// receiver passes to the status register bank.
package spiwp_pkg;
    localparam logic [7:0] OP_WR_STATUS = 8'h01;
    localparam logic [7:0] OP_CLR_WEL   = 8'h04;
    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_SET_WEL   = 8'h06;

    localparam int OP_BITS    = 8;
    localparam int FRAME_BITS = 16;

    // One-cycle events raised when chip-select closes a well-formed frame.
    typedef struct packed {
        logic       set_wel;
        logic       clr_wel;
        logic       wr_status;
        logic       new_lock_en;
        logic [1:0] new_level;
    } frame_evt_t;
endpackage

// File: rtl/spiwp_frame_rx.sv
// Frame receiver: detects SPI clock and chip-select edges on the system
// clock, counts and shifts bits, captures opcode and data, raises events
// at frame end and shifts the status byte out for status reads.
// Assumes spi_* inputs are already synchronous to clk.
module spiwp_frame_rx
    import spiwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_clk,
    input  logic       spi_sel_n,
    input  logic       spi_mosi,
    input  logic [7:0] status_byte,
    output frame_evt_t evt,
    output logic       miso_bit,
    output logic       rd_active
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT      = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_OP_LAST  = CNT_W'(OP_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_OP       = CNT_W'(OP_BITS);
    localparam logic [CNT_W-1:0] CNT_FR_LAST  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FR       = CNT_W'(FRAME_BITS);

    logic             sck_q;
    logic             sel_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [6:0]       shreg;
    logic [7:0]       opcode;
    logic             dat_lock;
    logic [1:0]       dat_level;
    logic [7:0]       out_sr;
    logic             sck_rise;
    logic             sck_fall;
    logic             frame_end;
    logic [7:0]       byte_now;

    assign sck_rise  = spi_clk & ~sck_q;
    assign sck_fall  = ~spi_clk & sck_q;
    assign frame_end = spi_sel_n & ~sel_q;
    assign byte_now  = {shreg, spi_mosi};

    // Edge history of the serial clock and chip-select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sel_q <= 1'b1;
        end else begin
            sck_q <= spi_clk;
            sel_q <= spi_sel_n;
        end
    end

    // Bit counter (saturating past a full frame) and input shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (spi_sel_n) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg <= byte_now[6:0];
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Opcode and data-field capture at the last bit of each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode    <= '0;
            dat_lock  <= 1'b0;
            dat_level <= '0;
        end else if (!spi_sel_n && sck_rise) begin
            if (bit_cnt == CNT_OP_LAST) opcode <= byte_now;
            if (bit_cnt == CNT_FR_LAST) begin
                dat_lock  <= byte_now[7];
                dat_level <= byte_now[3:2];
            end
        end
    end

    // Read-out shifter: loads status after a read opcode, advances on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            out_sr    <= '0;
            miso_bit  <= 1'b0;
        end else if (spi_sel_n) begin
            rd_active <= 1'b0;
        end else if (sck_rise && bit_cnt == CNT_OP_LAST && byte_now == OP_RD_STATUS) begin
            rd_active <= 1'b1;
            out_sr    <= status_byte;
        end else if (sck_fall && rd_active) begin
            miso_bit <= out_sr[7];
            out_sr   <= {out_sr[6:0], out_sr[7]};
        end
    end

    // Frame-end events, qualified by the exact bit count of the frame.
    always_comb begin
        evt             = '0;
        evt.set_wel     = frame_end && bit_cnt == CNT_OP && opcode == OP_SET_WEL;
        evt.clr_wel     = frame_end && bit_cnt == CNT_OP && opcode == OP_CLR_WEL;
        evt.wr_status   = frame_end && bit_cnt == CNT_FR && opcode == OP_WR_STATUS;
        evt.new_lock_en = dat_lock;
        evt.new_level   = dat_level;
    end
endmodule

// File: rtl/spiwp_status.sv
// Status register bank: holds the lock-enable bit, the protection level
// and the write-enable latch, and applies frame events and request strobes.
// A request strobe clearing the latch wins over a same-cycle set event.
module spiwp_status
    import spiwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  frame_evt_t evt,
    input  logic       req_done,
    input  logic       wr_lock_n,
    output logic       lock_en,
    output logic [1:0] level,
    output logic       wel,
    output logic       hw_lock
);
    assign hw_lock = ~wr_lock_n & lock_en;

    // Nonvolatile bits: commit a status write when enabled and not locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_en <= 1'b0;
            level   <= '0;
        end else if (evt.wr_status && wel && !hw_lock) begin
            lock_en <= evt.new_lock_en;
            level   <= evt.new_level;
        end
    end

    // Write-enable latch: set by its command, cleared by any completed write attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (req_done || evt.wr_status || evt.clr_wel) begin
            wel <= 1'b0;
        end else if (evt.set_wel) begin
            wel <= 1'b1;
        end
    end
endmodule

// File: rtl/spiwp_range_dec.sv
// Protection range decode: flags an address that lies inside the region
// fenced by the two-bit level (none, top quarter, top half, all).
module spiwp_range_dec #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              fenced
);
    localparam logic [ADDR_W:0] DEPTH   = (ADDR_W+1)'(1) << ADDR_W;
    localparam logic [ADDR_W:0] QUARTER = DEPTH >> 2;
    localparam logic [ADDR_W:0] HALF    = DEPTH >> 1;

    logic [ADDR_W:0] floor_addr;

    // Lowest fenced address for each level; DEPTH means nothing is fenced.
    always_comb begin
        unique case (level)
            2'b00:   floor_addr = DEPTH;
            2'b01:   floor_addr = DEPTH - QUARTER;
            2'b10:   floor_addr = HALF;
            default: floor_addr = '0;
        endcase
    end

    assign fenced = {1'b0, addr} >= floor_addr;
endmodule

// File: rtl/spiwp_ctrl.sv
// Top level of the write-protection front end. Combines the frame
// receiver, the status bank and the range decoder, and forms the two
// write-permit outputs. Assumes SPI pins are synchronous to clk.
module spiwp_ctrl
    import spiwp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_clk,
    input  logic              spi_sel_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              wr_lock_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_permit,
    output logic              st_permit,
    output logic [7:0]        status_byte
);
    frame_evt_t evt;
    logic       lock_en;
    logic [1:0] level;
    logic       wel;
    logic       hw_lock;
    logic       fenced;
    logic       rd_active;
    logic       miso_bit;

    spiwp_frame_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_clk     (spi_clk),
        .spi_sel_n   (spi_sel_n),
        .spi_mosi    (spi_mosi),
        .status_byte (status_byte),
        .evt         (evt),
        .miso_bit    (miso_bit),
        .rd_active   (rd_active)
    );

    spiwp_status u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .req_done  (req_valid),
        .wr_lock_n (wr_lock_n),
        .lock_en   (lock_en),
        .level     (level),
        .wel       (wel),
        .hw_lock   (hw_lock)
    );

    spiwp_range_dec #(.ADDR_W(ADDR_W)) u_rng (
        .level  (level),
        .addr   (req_addr),
        .fenced (fenced)
    );

    assign status_byte = {lock_en, 3'b000, level, wel, 1'b0};
    assign req_permit  = wel & ~fenced;
    assign st_permit   = wel & ~hw_lock;
    assign spi_miso    = miso_bit;
    assign spi_miso_oe = rd_active & ~spi_sel_n;
endmodule

// File: rtl/spiwp_ctrl_chk.sv
// Port-level property checker for spiwp_ctrl, attached by bind.
module spiwp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_sel_n,
    input logic       spi_miso_oe,
    input logic       wr_lock_n,
    input logic       req_valid,
    input logic       req_permit,
    input logic       st_permit,
    input logic [7:0] status_byte
);
    assert_nv_stable_sel_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sel_n |=> $stable({status_byte[7], status_byte[3:2]}));

    assert_req_clears_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !status_byte[1]);

    assert_lock_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lock_n && status_byte[7]) |=> $stable({status_byte[7], status_byte[3:2]}));

    assert_lock_no_st_permit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lock_n && status_byte[7]) |-> !st_permit);

    assert_level0_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[1] && status_byte[3:2] == 2'b00) |-> req_permit);

    assert_level3_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !req_permit);

    assert_no_wel_no_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[1] |-> (!req_permit && !st_permit));

    assert_miso_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sel_n |-> !spi_miso_oe);
endmodule

bind spiwp_ctrl spiwp_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sel_n   (spi_sel_n),
    .spi_miso_oe (spi_miso_oe),
    .wr_lock_n   (wr_lock_n),
    .req_valid   (req_valid),
    .req_permit  (req_permit),
    .st_permit   (st_permit),
    .status_byte (status_byte)
);

// File: tb/spiwp_ctrl_tb.sv
module spiwp_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_clk = 1'b0;
    logic        spi_sel_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        wr_lock_n = 1'b1;
    logic        req_valid = 1'b0;
    logic [10:0] req_addr = '0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic        req_permit;
    logic        st_permit;
    logic [7:0]  status_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit saw_oe = 1'b0;

    // reference model state
    bit       m_sck_p = 0, m_sel_p = 1;
    int       m_cnt = 0, m_k = 0;
    logic [7:0] m_sh = 0, m_op = 0, m_dat = 0, m_out = 0;
    bit       m_en = 0, m_wel = 0, m_rd = 0, m_miso = 0, m_mvalid = 0;
    logic [1:0] m_lvl = 0;

    always #2 clk = ~clk;

    spiwp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .wr_lock_n(wr_lock_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_permit(req_permit), .st_permit(st_permit), .status_byte(status_byte)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {m_en, 3'b000, m_lvl, m_wel, 1'b0};
    endfunction

    function automatic bit in_fence(input logic [1:0] lvl, input logic [10:0] a);
        case (lvl)
            2'b00: return 1'b0;
            2'b01: return a >= 11'h600;
            2'b10: return a >= 11'h400;
            default: return 1'b1;
        endcase
    endfunction

    // Behavioural reference model, advanced on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sck_p = 0; m_sel_p = 1; m_cnt = 0; m_en = 0; m_lvl = 0; m_wel = 0;
            m_rd = 0; m_mvalid = 0; m_op = 0; m_dat = 0;
        end else begin
            if (spi_sel_n) begin
                if (!m_sel_p) begin
                    if (m_cnt == 8 && m_op == 8'h06) m_wel = 1;
                    if (m_cnt == 8 && m_op == 8'h04) m_wel = 0;
                    if (m_cnt == 16 && m_op == 8'h01) begin
                        if (m_wel && !(!wr_lock_n && m_en)) begin
                            m_en = m_dat[7];
                            m_lvl = m_dat[3:2];
                        end
                        m_wel = 0;
                    end
                end
                m_cnt = 0; m_rd = 0; m_mvalid = 0;
            end else begin
                if (spi_clk && !m_sck_p) begin
                    m_sh = {m_sh[6:0], spi_mosi};
                    if (m_cnt < 17) m_cnt++;
                    if (m_cnt == 8) begin
                        m_op = m_sh;
                        if (m_sh == 8'h05) begin m_rd = 1; m_out = m_status(); m_k = 0; end
                    end
                    if (m_cnt == 16) m_dat = m_sh;
                end
                if (!spi_clk && m_sck_p && m_rd) begin
                    m_miso = m_out[7 - m_k];
                    m_k = (m_k + 1) % 8;
                    m_mvalid = 1;
                end
            end
            if (req_valid) m_wel = 0;
            m_sck_p = spi_clk; m_sel_p = spi_sel_n;
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(status_byte == m_status(), "R4 status byte", status_byte, m_status());
            chk(req_permit == (m_wel && !in_fence(m_lvl, req_addr)), "R8/R9 req_permit",
                req_permit, m_wel && !in_fence(m_lvl, req_addr));
            chk(st_permit == (m_wel && !(!wr_lock_n && m_en)), "R6 st_permit",
                st_permit, m_wel && !(!wr_lock_n && m_en));
            chk(spi_miso_oe == (m_rd && !spi_sel_n), "R10 miso_oe", spi_miso_oe, m_rd && !spi_sel_n);
            if (m_mvalid && spi_miso_oe)
                chk(spi_miso == m_miso, "R11 miso bit", spi_miso, m_miso);
            if (spi_miso_oe) saw_oe = 1'b1;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk); spi_clk = 0; spi_mosi = b;
        wait_clk(3);
        spi_clk = 1;
        wait_clk(3);
    endtask

    task automatic frame(input logic [31:0] v, input int n);
        @(negedge clk); spi_sel_n = 0; saw_oe = 0;
        wait_clk(2);
        for (int i = 0; i < n; i++) send_bit(v[n - 1 - i]);
        @(negedge clk); spi_clk = 0;
        wait_clk(2);
        spi_sel_n = 1;
        wait_clk(3);
    endtask

    task automatic read_status(output logic [15:0] v);
        @(negedge clk); spi_sel_n = 0;
        wait_clk(2);
        for (int i = 0; i < 8; i++) send_bit(8'h05 >> (7 - i));
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); spi_clk = 0;
            wait_clk(3);
            v[15 - i] = spi_miso;
            spi_clk = 1;
            wait_clk(3);
        end
        @(negedge clk); spi_clk = 0;
        wait_clk(2);
        spi_sel_n = 1;
        wait_clk(3);
    endtask

    task automatic permit_at(input logic [10:0] a, input bit exp, input string tag);
        @(negedge clk); req_addr = a;
        wait_clk(1);
        chk(req_permit == exp, tag, req_permit, exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        wait_clk(5);
        rst_n = 1;
        wait_clk(2);
        chk(status_byte == 8'h00, "R4 reset status", status_byte, 8'h00);
        chk(!req_permit && !st_permit, "R9 permits low at reset", {req_permit, st_permit}, 0);

        frame({8'h01, 8'hFF}, 16);
        chk(status_byte == 8'h00, "R1 no write without latch", status_byte, 8'h00);
        frame(8'h06, 8);
        chk(status_byte == 8'h02, "R3 set latch", status_byte, 8'h02);
        frame({8'h01, 8'hFF}, 16);
        chk(status_byte == 8'h8C, "R1/R5 write commits, latch cleared", status_byte, 8'h8C);
        chk(!saw_oe, "R10 no drive during status write", saw_oe, 0);
        frame(8'h06, 8);
        permit_at(11'h000, 0, "R8 level 3 fences 0x000");

        @(negedge clk); wr_lock_n = 0;
        wait_clk(1);
        chk(!st_permit, "R6 lock blocks status permit", st_permit, 0);
        frame({8'h01, 8'h00}, 16);
        chk(status_byte == 8'h8C, "R6/R5 locked write refused, latch cleared", status_byte, 8'h8C);

        @(negedge clk); wr_lock_n = 1;
        frame(8'h06, 8);
        frame({8'h01, 8'h84}, 16);
        chk(status_byte == 8'h84, "R1 level 01 written", status_byte, 8'h84);
        read_status(rv);
        chk(rv == 16'h8484, "R11 status read repeats", rv, 16'h8484);
        frame(8'h06, 8);
        permit_at(11'h5FF, 1, "R8 level 1 below fence");
        permit_at(11'h600, 0, "R8 level 1 fence start");
        permit_at(11'h7FF, 0, "R8 level 1 top");
        @(negedge clk); wr_lock_n = 0;
        permit_at(11'h5FF, 1, "R7 lock pin ignored for array");
        @(negedge clk); wr_lock_n = 1;

        @(negedge clk); req_valid = 1; req_addr = 11'h100;
        @(negedge clk); req_valid = 0;
        chk(status_byte == 8'h84, "R5 request clears latch", status_byte, 8'h84);

        frame(8'h06, 8);
        frame({8'h01, 4'h0}, 12);
        chk(status_byte == 8'h86, "R2 short frame ignored", status_byte, 8'h86);
        frame({8'h01, 8'h00, 4'h0}, 20);
        chk(status_byte == 8'h86, "R2 long frame ignored", status_byte, 8'h86);
        frame(8'h04, 8);
        chk(status_byte == 8'h84, "R3 clear latch", status_byte, 8'h84);

        frame(8'h06, 8);
        frame({8'h01, 8'h08}, 16);
        chk(status_byte == 8'h08, "R1 level 10, lock bit off", status_byte, 8'h08);
        @(negedge clk); wr_lock_n = 0;
        frame(8'h06, 8);
        chk(st_permit, "R6 lock inactive while enable bit low", st_permit, 1);
        permit_at(11'h3FF, 1, "R8 level 2 below fence");
        permit_at(11'h400, 0, "R8 level 2 fence start");
        frame({8'h01, 8'h00}, 16);
        chk(status_byte == 8'h00, "R6 write allowed with pin low, enable low", status_byte, 8'h00);
        frame(8'h06, 8);
        permit_at(11'h7FF, 1, "R8 level 0 opens top");
        @(negedge clk); wr_lock_n = 1;
        read_status(rv);
        chk(rv == 16'h0202, "R11 status read with latch", rv, 16'h0202);
        chk(!spi_miso_oe, "R10 released after select high", spi_miso_oe, 0);
        chk((status_byte & 8'h71) == 0, "R4 reserved bits zero", status_byte, status_byte & 8'h8E);

        wait_clk(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule